// File: doc/BRIEF.md
# Write-Update Snooping Line Controller

This block keeps the coherence state of a single cache line in a write-back cache whose peers share a snooping bus and use an update protocol. When a processor writes a line that other caches also hold, only the written word is broadcast, and every holder patches its copy instead of losing it. A line that is present is never invalid. It is in one of four states: exclusive-clean (this cache and memory agree), shared-clean (peers hold it and this cache does not own it), shared-owned (peers hold it, memory is stale, and this cache must supply and write it back) or modified (the only copy, dirty). A line that is not in the cache is tracked as absent.

The processor side presents read, write and evict requests. It receives a completion strobe and a strobe that allows the word to be written into the local data array. The bus side requests the bus, names the transaction it wants, and samples the wired-OR shared line in the cycle it is granted. The snoop side receives other caches' transactions together with an external tag-match flag. It answers with a shared indication, a flush request for owned data, and a strobe that applies a snooped word to the local copy. The data array, the arbiter and memory are outside the block.

Top module: `wu_snoop_line`

## Requirements
- R1: During and after synchronous active-low reset the line is absent (`line_state` = 0) and `bus_req` is low. The state encodings are absent 0, exclusive-clean 1, shared-clean 2, shared-owned 3, modified 4.
- R2: A read request (`cpu_op` = 0) to an absent line requests the bus with a read (`bus_cmd` = 1). In the grant cycle it completes, and the line becomes shared-clean if `bus_shared` is high and exclusive-clean if it is low.
- R3: A read request to a present line completes in the same cycle without requesting the bus.
- R4: A write request (`cpu_op` = 1) to an exclusive-clean or modified line completes in the same cycle, with `cpu_word_wr` high and no bus request, and the line becomes modified.
- R5: A write request to a shared-clean or shared-owned line requests a word update (`bus_cmd` = 2). `cpu_word_wr` stays low until the grant cycle and is high in that cycle. The line then becomes shared-owned if `bus_shared` was high and modified if it was low.
- R6: A matching snooped read (`snp_cmd` = 1) to a present line raises `snp_shared_out`. A modified or shared-owned line also raises `snp_flush` and becomes or stays shared-owned. An exclusive-clean line becomes shared-clean.
- R7: A matching snooped word update (`snp_cmd` = 2) to a present line raises `snp_word_wr`, and the line becomes shared-clean; a shared-owned holder gives up ownership.
- R8: An evict request (`cpu_op` = 2) to a modified or shared-owned line requests a writeback (`bus_cmd` = 3) and makes the line absent after the grant. An evict of a clean or absent line completes in the same cycle without the bus.
- R9: A write request to an absent line first issues a read. If `bus_shared` is low at that grant, the write completes in the same cycle, with `cpu_word_wr` high, and the line becomes modified. Otherwise the line becomes shared-clean and a word update follows as in R5.
- R10: A snoop with `snp_hit` low, or to an absent line, raises no response and leaves the state unchanged.
- R11: A pending writeback whose line loses ownership to a snooped update before the grant completes silently, without a bus request, and the line becomes absent.
- R12: When a snoop and a new processor request arrive in the same cycle, the snoop takes effect first, and the request is decided on the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request strobe, one cycle |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_word_wr | output | 1 | Write the processor word into the local copy |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 0 none, 1 read, 2 word update, 3 writeback |
| bus_gnt | input | 1 | Bus granted to this controller |
| bus_shared | input | 1 | Wired-OR shared line, sampled at grant |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, 1 read, 2 word update |
| snp_hit | input | 1 | Snooped address matches this line |
| snp_shared_out | output | 1 | Drive the wired-OR shared line |
| snp_flush | output | 1 | Supply the owned line on the bus |
| snp_word_wr | output | 1 | Apply the snooped word to the local copy |
| line_state | output | 3 | Current coherence state |

## Verification
Two functions can meet in one cycle: a snooped transaction and a processor request, or a snooped update and a writeback that has not yet been granted. The bench provokes both. It presents a write request to a modified line in the same cycle as a matching snooped read, and it sends a snooped update to a shared-owned line while that line's evict is waiting for the bus. It judges the result by the flush strobe, by the absence of a local write before the later grant, by the command issued, and by the final state of the line.

// File: rtl/wu_pkg.sv
// Shared types for the write-update line controller.
// Assumes one coherence state per cache line and a single shared bus.
package wu_pkg;
    localparam int ST_W  = 3;
    localparam int CMD_W = 2;
    localparam int OP_W  = 2;

    typedef enum logic [ST_W-1:0] {
        LN_ABSENT = 3'd0,
        LN_EXCL   = 3'd1,
        LN_SCLN   = 3'd2,
        LN_SOWN   = 3'd3,
        LN_MOD    = 3'd4
    } line_st_e;

    typedef enum logic [CMD_W-1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_UPD  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [OP_W-1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_EV  = 2'd2,
        OP_NOP = 2'd3
    } cpu_op_e;
endpackage

// File: rtl/wu_snoop_resp.sv
// Snoop responder: applies a matching snooped transaction to the current
// state and produces the shared, flush and word-apply responses.
// Assumes the snoop inputs never describe this controller's own transaction;
// own_gnt masks them in the cycle this controller owns the bus.
module wu_snoop_resp
    import wu_pkg::*;
(
    input  line_st_e cur_st,
    input  logic     snp_valid,
    input  bus_cmd_e snp_cmd,
    input  logic     snp_hit,
    input  logic     own_gnt,
    output line_st_e eff_st,
    output logic     shared_out,
    output logic     flush,
    output logic     word_wr
);
    logic active;

    // Snoop applies only to a present line that matches, when the bus is not ours
    assign active = snp_valid && snp_hit && !own_gnt && (cur_st != LN_ABSENT);

    // Post-snoop state and responses
    always_comb begin
        eff_st     = cur_st;
        shared_out = 1'b0;
        flush      = 1'b0;
        word_wr    = 1'b0;
        if (active) begin
            shared_out = 1'b1;
            case (snp_cmd)
                BC_RD: begin
                    if (cur_st == LN_MOD || cur_st == LN_SOWN) begin
                        flush  = 1'b1;
                        eff_st = LN_SOWN;
                    end else begin
                        eff_st = LN_SCLN;
                    end
                end
                BC_UPD: begin
                    word_wr = 1'b1;
                    eff_st  = LN_SCLN;
                end
                default: eff_st = cur_st;
            endcase
        end
    end
endmodule

// File: rtl/wu_cpu_seq.sv
// Processor-side sequencer: serves hits locally, holds one pending request
// that needs the bus, and computes the next line state from the post-snoop
// state. Assumes cpu_req is a one-cycle strobe and is ignored while busy.
module wu_cpu_seq
    import wu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  line_st_e eff_st,
    input  logic     cpu_req,
    input  cpu_op_e  cpu_op,
    input  logic     bus_gnt,
    input  logic     bus_shared,
    output logic     busy,
    output logic     bus_req,
    output bus_cmd_e bus_cmd,
    output logic     cpu_done,
    output logic     cpu_word_wr,
    output line_st_e nxt_st
);
    cpu_op_e op_q, op_d;
    logic    busy_d;
    logic    owned, wr_local;

    assign owned    = (eff_st == LN_MOD) || (eff_st == LN_SOWN);
    assign wr_local = (eff_st == LN_MOD) || (eff_st == LN_EXCL);

    // Decide bus use, completion and next state
    always_comb begin
        bus_req     = 1'b0;
        bus_cmd     = BC_NONE;
        cpu_done    = 1'b0;
        cpu_word_wr = 1'b0;
        nxt_st      = eff_st;
        busy_d      = busy;
        op_d        = op_q;
        if (!busy) begin
            if (cpu_req) begin
                case (cpu_op)
                    OP_RD: begin
                        if (eff_st != LN_ABSENT) cpu_done = 1'b1;
                        else begin busy_d = 1'b1; op_d = OP_RD; end
                    end
                    OP_WR: begin
                        if (wr_local) begin
                            cpu_done    = 1'b1;
                            cpu_word_wr = 1'b1;
                            nxt_st      = LN_MOD;
                        end else begin
                            busy_d = 1'b1;
                            op_d   = OP_WR;
                        end
                    end
                    OP_EV: begin
                        if (owned) begin busy_d = 1'b1; op_d = OP_EV; end
                        else begin cpu_done = 1'b1; nxt_st = LN_ABSENT; end
                    end
                    default: ;
                endcase
            end
        end else begin
            case (op_q)
                OP_RD: begin
                    bus_req = 1'b1;
                    bus_cmd = BC_RD;
                    if (bus_gnt) begin
                        cpu_done = 1'b1;
                        nxt_st   = bus_shared ? LN_SCLN : LN_EXCL;
                        busy_d   = 1'b0;
                    end
                end
                OP_WR: begin
                    if (wr_local) begin
                        cpu_done    = 1'b1;
                        cpu_word_wr = 1'b1;
                        nxt_st      = LN_MOD;
                        busy_d      = 1'b0;
                    end else if (eff_st == LN_ABSENT) begin
                        bus_req = 1'b1;
                        bus_cmd = BC_RD;
                        if (bus_gnt) begin
                            if (bus_shared) nxt_st = LN_SCLN;
                            else begin
                                nxt_st      = LN_MOD;
                                cpu_word_wr = 1'b1;
                                cpu_done    = 1'b1;
                                busy_d      = 1'b0;
                            end
                        end
                    end else begin
                        bus_req = 1'b1;
                        bus_cmd = BC_UPD;
                        if (bus_gnt) begin
                            cpu_word_wr = 1'b1;
                            cpu_done    = 1'b1;
                            nxt_st      = bus_shared ? LN_SOWN : LN_MOD;
                            busy_d      = 1'b0;
                        end
                    end
                end
                OP_EV: begin
                    if (owned) begin
                        bus_req = 1'b1;
                        bus_cmd = BC_WB;
                        if (bus_gnt) begin
                            cpu_done = 1'b1;
                            nxt_st   = LN_ABSENT;
                            busy_d   = 1'b0;
                        end
                    end else begin
                        cpu_done = 1'b1;
                        nxt_st   = LN_ABSENT;
                        busy_d   = 1'b0;
                    end
                end
                default: busy_d = 1'b0;
            endcase
        end
    end

    // Pending-request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            op_q <= OP_NOP;
        end else begin
            busy <= busy_d;
            op_q <= op_d;
        end
    end
endmodule

// File: rtl/wu_snoop_line.sv
// Write-update snooping controller for one cache line. Holds the coherence
// state; snoop effects are applied before processor decisions in a cycle.
// Assumes a grant to this controller while it has a request pending means
// the bus carries its own transaction, so snoop inputs are ignored then.
module wu_snoop_line
    import wu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic [OP_W-1:0]     cpu_op,
    output logic                cpu_done,
    output logic                cpu_word_wr,
    output logic                bus_req,
    output logic [CMD_W-1:0]    bus_cmd,
    input  logic                bus_gnt,
    input  logic                bus_shared,
    input  logic                snp_valid,
    input  logic [CMD_W-1:0]    snp_cmd,
    input  logic                snp_hit,
    output logic                snp_shared_out,
    output logic                snp_flush,
    output logic                snp_word_wr,
    output logic [ST_W-1:0]     line_state
);
    line_st_e st_q, eff_st, nxt_st;
    bus_cmd_e cmd_int;
    logic     busy;

    wu_snoop_resp u_snoop (
        .cur_st     (st_q),
        .snp_valid  (snp_valid),
        .snp_cmd    (bus_cmd_e'(snp_cmd)),
        .snp_hit    (snp_hit),
        .own_gnt    (busy && bus_gnt),
        .eff_st     (eff_st),
        .shared_out (snp_shared_out),
        .flush      (snp_flush),
        .word_wr    (snp_word_wr)
    );

    wu_cpu_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .eff_st      (eff_st),
        .cpu_req     (cpu_req),
        .cpu_op      (cpu_op_e'(cpu_op)),
        .bus_gnt     (bus_gnt),
        .bus_shared  (bus_shared),
        .busy        (busy),
        .bus_req     (bus_req),
        .bus_cmd     (cmd_int),
        .cpu_done    (cpu_done),
        .cpu_word_wr (cpu_word_wr),
        .nxt_st      (nxt_st)
    );

    assign bus_cmd    = cmd_int;
    assign line_state = st_q;

    // Coherence state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LN_ABSENT;
        else        st_q <= nxt_st;
    end
endmodule

// File: rtl/wu_snoop_line_chk.sv
// Checker for wu_snoop_line: protocol properties observed at the ports.
module wu_snoop_line_chk
    import wu_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req,
    input logic [OP_W-1:0]  cpu_op,
    input logic             cpu_done,
    input logic             cpu_word_wr,
    input logic             bus_req,
    input logic [CMD_W-1:0] bus_cmd,
    input logic             bus_gnt,
    input logic             bus_shared,
    input logic             snp_valid,
    input logic [CMD_W-1:0] snp_cmd,
    input logic             snp_hit,
    input logic             snp_shared_out,
    input logic             snp_flush,
    input logic             snp_word_wr,
    input logic [ST_W-1:0]  line_state
);
    // R1
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_state <= 3'd4);

    // R5
    local_wr_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_word_wr |-> (line_state == 3'd1 || line_state == 3'd4 || (bus_req && bus_gnt)));

    // R4
    local_wr_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_word_wr |=> (line_state == 3'd3 || line_state == 3'd4));

    // R6
    flush_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> (line_state == 3'd3 || line_state == 3'd4));

    // R6
    flush_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_flush && !cpu_done) |=> line_state == 3'd3);

    // R7
    upd_drop_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_word_wr && line_state == 3'd3) |=> (line_state == 3'd2 || line_state == 3'd0));

    // R8
    wb_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd3) |-> (line_state == 3'd3 || line_state == 3'd4));

    // R8
    wb_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == 2'd3) |=> line_state == 3'd0);

    // R10
    resp_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared_out |-> (snp_hit && snp_valid && line_state != 3'd0));
endmodule

bind wu_snoop_line wu_snoop_line_chk u_chk (.*);

// File: tb/tb_wu_snoop_line.sv
module tb_wu_snoop_line;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0;
    logic [1:0] cpu_op = 2'd3;
    logic       cpu_done, cpu_word_wr, bus_req;
    logic [1:0] bus_cmd;
    logic       bus_gnt = 1'b0, bus_shared = 1'b0;
    logic       snp_valid = 1'b0, snp_hit = 1'b0;
    logic [1:0] snp_cmd = 2'd0;
    logic       snp_shared_out, snp_flush, snp_word_wr;
    logic [2:0] line_state;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct { string tag; int kind; int val; } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    wu_snoop_line dut (.*);

    // Driver side: queue an expected output value for the current cycle
    task automatic expect_o(string tag, int kind, int val);
        exp_t e;
        e.tag = tag; e.kind = kind; e.val = val;
        sb_q.push_back(e);
    endtask

    // Advance one cycle and drive every input
    task automatic drive(bit rq, int op, bit g, bit sh, bit sv, int sc, bit hit);
        @(posedge clk); #1;
        cpu_req = rq; cpu_op = 2'(op); bus_gnt = g; bus_shared = sh;
        snp_valid = sv; snp_cmd = 2'(sc); snp_hit = hit;
    endtask

    task automatic idle();
        drive(0, 3, 0, 0, 0, 0, 0);
    endtask

    function automatic int observe(int kind);
        case (kind)
            0: return int'(line_state);
            1: return int'(cpu_done);
            2: return int'(cpu_word_wr);
            3: return int'(bus_req);
            4: return int'(bus_cmd);
            5: return int'(snp_flush);
            6: return int'(snp_shared_out);
            default: return int'(snp_word_wr);
        endcase
    endfunction

    // Monitor: pop and compare the expectations away from the clock edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            int act;
            e = sb_q.pop_front();
            act = observe(e.kind);
            n_chk++;
            if (act != e.val) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%0d expected=%0d", e.tag, e.kind, act, e.val);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_o("R1 reset state", 0, 0);
        expect_o("R1 no request", 3, 0);

        // R10: snoop to an absent line
        drive(0, 3, 0, 0, 1, 1, 1);
        expect_o("R10 absent no shared", 6, 0);

        // R2: read miss, shared low
        drive(1, 0, 0, 0, 0, 0, 0);
        expect_o("R2 miss not done", 1, 0);
        drive(0, 3, 1, 0, 0, 0, 0);
        expect_o("R2 read cmd", 4, 1);
        expect_o("R2 done at grant", 1, 1);
        idle();
        expect_o("R2 exclusive", 0, 1);

        // R3: read hit
        drive(1, 0, 0, 0, 0, 0, 0);
        expect_o("R3 hit done", 1, 1);
        expect_o("R3 no bus", 3, 0);

        // R4: write hit on exclusive
        drive(1, 1, 0, 0, 0, 0, 0);
        expect_o("R4 done", 1, 1);
        expect_o("R4 local write", 2, 1);
        expect_o("R4 no bus", 3, 0);
        idle();
        expect_o("R4 modified", 0, 4);

        // R6: snooped read on modified
        drive(0, 3, 0, 0, 1, 1, 1);
        expect_o("R6 flush", 5, 1);
        expect_o("R6 shared out", 6, 1);
        idle();
        expect_o("R6 owner", 0, 3);

        // R5: write hit on shared-owned with delayed grant
        drive(1, 1, 0, 0, 0, 0, 0);
        expect_o("R5 no early write", 2, 0);
        expect_o("R5 not done", 1, 0);
        idle();
        expect_o("R5 update cmd", 4, 2);
        expect_o("R5 still no write", 2, 0);
        drive(0, 3, 1, 1, 0, 0, 0);
        expect_o("R5 write at grant", 2, 1);
        expect_o("R5 done at grant", 1, 1);
        idle();
        expect_o("R5 stays owner", 0, 3);

        // R7: snooped update on shared-owned
        drive(0, 3, 0, 0, 1, 2, 1);
        expect_o("R7 apply word", 7, 1);
        expect_o("R7 no flush", 5, 0);
        idle();
        expect_o("R7 shared-clean", 0, 2);

        // R5: write hit on shared-clean, shared low
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(0, 3, 1, 0, 0, 0, 0);
        expect_o("R5 write at grant sc", 2, 1);
        idle();
        expect_o("R5 modified", 0, 4);

        // R8: evict dirty
        drive(1, 2, 0, 0, 0, 0, 0);
        expect_o("R8 evict waits", 1, 0);
        drive(0, 3, 1, 0, 0, 0, 0);
        expect_o("R8 writeback cmd", 4, 3);
        expect_o("R8 done", 1, 1);
        idle();
        expect_o("R8 absent", 0, 0);

        // R2: read miss, shared high; R8 clean evict
        drive(1, 0, 0, 0, 0, 0, 0);
        drive(0, 3, 1, 1, 0, 0, 0);
        idle();
        expect_o("R2 shared-clean", 0, 2);
        drive(1, 2, 0, 0, 0, 0, 0);
        expect_o("R8 silent done", 1, 1);
        expect_o("R8 silent no bus", 3, 0);
        idle();
        expect_o("R8 clean absent", 0, 0);

        // R9: write miss with sharers
        drive(1, 1, 0, 0, 0, 0, 0);
        expect_o("R9 not done", 1, 0);
        drive(0, 3, 1, 1, 0, 0, 0);
        expect_o("R9 read leg", 4, 1);
        expect_o("R9 no write on read", 2, 0);
        expect_o("R9 not done after read", 1, 0);
        idle();
        expect_o("R9 interim shared-clean", 0, 2);
        expect_o("R9 update leg", 4, 2);
        drive(0, 3, 1, 1, 0, 0, 0);
        expect_o("R9 write at update", 2, 1);
        expect_o("R9 done", 1, 1);
        idle();
        expect_o("R9 owner", 0, 3);

        // R10: non-matching snoop
        drive(0, 3, 0, 0, 1, 2, 0);
        expect_o("R10 no shared", 6, 0);
        expect_o("R10 no apply", 7, 0);
        idle();
        expect_o("R10 unchanged", 0, 3);

        // R11: pending writeback loses ownership
        drive(1, 2, 0, 0, 0, 0, 0);
        expect_o("R11 waits", 1, 0);
        drive(0, 3, 0, 0, 1, 2, 1);
        expect_o("R11 silent done", 1, 1);
        expect_o("R11 no request", 3, 0);
        idle();
        expect_o("R11 absent", 0, 0);

        // R9: write miss without sharers
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(0, 3, 1, 0, 0, 0, 0);
        expect_o("R9 direct write", 2, 1);
        expect_o("R9 direct done", 1, 1);
        idle();
        expect_o("R9 modified", 0, 4);

        // R12: snooped read and write request in one cycle
        drive(1, 1, 0, 0, 1, 1, 1);
        expect_o("R12 flush first", 5, 1);
        expect_o("R12 no local write", 2, 0);
        expect_o("R12 not done", 1, 0);
        drive(0, 3, 1, 1, 0, 0, 0);
        expect_o("R12 update cmd", 4, 2);
        expect_o("R12 write at grant", 2, 1);
        idle();
        expect_o("R12 owner", 0, 3);

        idle();
        idle();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule